// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 36-bit data buses, called A and B, and forwards data across them in either direction or in both. Each direction owns a storage register, a capture strobe, an output enable and a source select. The select picks one of two sources for the outgoing bus: the live value on the opposite bus, or the word held in that direction's register. The word is cut into four 9-bit lanes. Every lane has its own copy of every control, so the block can serve as four narrow transceivers, two half-width ones, or one full-width one.

Neither bus is a real tri-state net. Each side is modelled by three vectors: an input carrying the external driver's value together with a per-lane "external driver present" flag, an output data vector, and a per-bit output-enable vector. The capture strobes are sampled on the block clock. A capture happens on the clock edge where a strobe is first seen high. Select and enable settings are registered before they steer the outputs. Because of that, the source mux switches only on a clock edge, and a live path and a stored path are never both selected.

When a lane has both selects on live and both directions enabled, the two buses drive each other. The block models this loop as a small holding register. That register follows whichever external driver is present and keeps its value once all external drivers let go.

Top module: `dual_bus_xcvr`

## Requirements
- R1: Lane l covers bits [9l+8:9l] of every data and enable vector, for l = 0 to 3. The controls of a lane affect only the bits of that lane.
- R2: A strobe on `capAbStb[l]` that is low in one cycle and high in the next stores lane l of `aIn` into the A-to-B register on that edge. `capBaStb[l]` stores `bIn` into the B-to-A register in the same way. Both can capture on the same edge. A strobe that stays high does not capture again.
- R3: Capture takes place whatever the settings of the selects and output enables.
- R4: The select level sampled on an edge applies from that edge on. `selAb[l]` = 0 makes `bOut` carry lane l of `aIn`, and `selAb[l]` = 1 makes it carry the A-to-B register. `selBa[l]` steers `aOut` from `bIn` or from the B-to-A register in the same way.
- R5: `oeAb[l]` = 1 (active high) sampled on an edge sets all 9 bits of lane l of `bOe` from that edge on. `oeBaN[l]` = 0 (active low) sets lane l of `aOe` in the same way.
- R6: A change on a select input has no effect on the outputs until the next clock edge. After that edge the lane shows exactly one source.
- R7: Self-hold is the case where, on the last edge, a lane had both selects at 0, `oeAb` = 1 and `oeBaN` = 0. In self-hold both buses carry the same value. That value is external A if `aDrv[l]` = 1, otherwise external B if `bDrv[l]` = 1, otherwise the last externally driven value, which is captured on every edge where either driver is present.
- R8: While `rstN` = 0 on an edge, both storage registers and the holding value of every lane are cleared to zero, and no capture happens. Enables and selects are still sampled during reset.
- R9: A disabled direction holds every bit of its output-enable lane at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous active-low reset of the storage |
| aIn | input | 36 | External driver value on bus A |
| aDrv | input | 4 | Per lane: an external driver is present on bus A |
| bIn | input | 36 | External driver value on bus B |
| bDrv | input | 4 | Per lane: an external driver is present on bus B |
| capAbStb | input | 4 | Per-lane capture strobe, A into A-to-B register |
| capBaStb | input | 4 | Per-lane capture strobe, B into B-to-A register |
| selAb | input | 4 | Per-lane source select toward B (0 live, 1 stored) |
| selBa | input | 4 | Per-lane source select toward A (0 live, 1 stored) |
| oeAb | input | 4 | Per-lane drive enable toward B, active high |
| oeBaN | input | 4 | Per-lane drive enable toward A, active low |
| aOut | output | 36 | Data the block drives onto bus A |
| aOe | output | 36 | Per-bit drive enable onto bus A |
| bOut | output | 36 | Data the block drives onto bus B |
| bOe | output | 36 | Per-bit drive enable onto bus B |

## Verification
The properties assume that every control input and strobe already has a defined value on the reset edges. This lets a comparison with the previous cycle right after reset refer to real values. They also assume that an external driver never competes with the block on a lane the block drives. The only exception is a lane in self-hold, where at most one side is driven from outside. The stimulus keeps within both limits. All inputs are driven from time zero. The drive flags for each cycle are derived from the enable and select values about to be sampled, so external data appears only on lanes that will be undriven by the block, or on one side of a self-hold lane.

// File: rtl/dual_bus_xcvr_pkg.sv
package dual_bus_xcvr_pkg;
  parameter int NUM_LANES = 4;

  // Per-lane strobes handed from control to datapath; live/stored/selfHold one-hot per direction
  typedef struct packed {
    logic [NUM_LANES-1:0] capAb;
    logic [NUM_LANES-1:0] capBa;
    logic [NUM_LANES-1:0] liveAb;
    logic [NUM_LANES-1:0] storedAb;
    logic [NUM_LANES-1:0] liveBa;
    logic [NUM_LANES-1:0] storedBa;
    logic [NUM_LANES-1:0] enAb;
    logic [NUM_LANES-1:0] enBa;
    logic [NUM_LANES-1:0] selfHold;
  } xcvrStrobes_t;
endpackage

// File: rtl/dual_bus_xcvr_ctrl.sv
module dual_bus_xcvr_ctrl
  import dual_bus_xcvr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LANES-1:0] capAbStb,
  input  logic [NUM_LANES-1:0] capBaStb,
  input  logic [NUM_LANES-1:0] selAb,
  input  logic [NUM_LANES-1:0] selBa,
  input  logic [NUM_LANES-1:0] oeAb,
  input  logic [NUM_LANES-1:0] oeBaN,
  output xcvrStrobes_t         strobes
);
  logic [NUM_LANES-1:0] capAbQ, capBaQ;
  logic [NUM_LANES-1:0] holdNext;
  logic [NUM_LANES-1:0] liveAbQ, storedAbQ, liveBaQ, storedBaQ;
  logic [NUM_LANES-1:0] enAbQ, enBaQ, selfHoldQ;

  // Strobe history tracks through reset so a strobe held across release does not fire
  always_ff @(posedge clk) begin
    capAbQ <= capAbStb;
    capBaQ <= capBaStb;
  end

  assign holdNext = ~selAb & ~selBa & oeAb & ~oeBaN;

  // Registered source decode: the datapath mux only ever sees clean one-hot selects
  always_ff @(posedge clk) begin
    selfHoldQ <= holdNext;
    storedAbQ <= selAb;
    liveAbQ   <= ~selAb & ~holdNext;
    storedBaQ <= selBa;
    liveBaQ   <= ~selBa & ~holdNext;
    enAbQ     <= oeAb;
    enBaQ     <= ~oeBaN;
  end

  assign strobes.capAb    = capAbStb & ~capAbQ & {NUM_LANES{rstN}};
  assign strobes.capBa    = capBaStb & ~capBaQ & {NUM_LANES{rstN}};
  assign strobes.liveAb   = liveAbQ;
  assign strobes.storedAb = storedAbQ;
  assign strobes.liveBa   = liveBaQ;
  assign strobes.storedBa = storedBaQ;
  assign strobes.enAb     = enAbQ;
  assign strobes.enBa     = enBaQ;
  assign strobes.selfHold = selfHoldQ;
endmodule

// File: rtl/dual_bus_xcvr_dp.sv
module dual_bus_xcvr_dp
  import dual_bus_xcvr_pkg::*;
#(
  parameter  int LANE_W = 9,
  localparam int BUS_W  = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xcvrStrobes_t         strobes,
  input  logic [BUS_W-1:0]     aIn,
  input  logic [NUM_LANES-1:0] aDrv,
  input  logic [BUS_W-1:0]     bIn,
  input  logic [NUM_LANES-1:0] bDrv,
  output logic [BUS_W-1:0]     aOut,
  output logic [BUS_W-1:0]     aOe,
  output logic [BUS_W-1:0]     bOut,
  output logic [BUS_W-1:0]     bOe
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] aLane, bLane;
    logic [LANE_W-1:0] regAb, regBa, holdVal, loopVal;

    assign aLane = aIn[l*LANE_W +: LANE_W];
    assign bLane = bIn[l*LANE_W +: LANE_W];

    // Loop value: an external driver wins, otherwise the loop keeps the last driven word
    assign loopVal = aDrv[l] ? aLane : (bDrv[l] ? bLane : holdVal);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regAb   <= '0;
        regBa   <= '0;
        holdVal <= '0;
      end else begin
        if (strobes.capAb[l]) regAb <= aLane;
        if (strobes.capBa[l]) regBa <= bLane;
        if (aDrv[l] || bDrv[l]) holdVal <= aDrv[l] ? aLane : bLane;
      end
    end

    // AND-OR mux on one-hot registered selects: one source term per lane at a time
    assign bOut[l*LANE_W +: LANE_W] = ({LANE_W{strobes.liveAb[l]}}   & aLane)
                                    | ({LANE_W{strobes.storedAb[l]}} & regAb)
                                    | ({LANE_W{strobes.selfHold[l]}} & loopVal);
    assign aOut[l*LANE_W +: LANE_W] = ({LANE_W{strobes.liveBa[l]}}   & bLane)
                                    | ({LANE_W{strobes.storedBa[l]}} & regBa)
                                    | ({LANE_W{strobes.selfHold[l]}} & loopVal);

    assign bOe[l*LANE_W +: LANE_W] = {LANE_W{strobes.enAb[l]}};
    assign aOe[l*LANE_W +: LANE_W] = {LANE_W{strobes.enBa[l]}};
  end
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
  import dual_bus_xcvr_pkg::*;
#(
  parameter  int LANE_W = 9,
  localparam int BUS_W  = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BUS_W-1:0]     aIn,
  input  logic [NUM_LANES-1:0] aDrv,
  input  logic [BUS_W-1:0]     bIn,
  input  logic [NUM_LANES-1:0] bDrv,
  input  logic [NUM_LANES-1:0] capAbStb,
  input  logic [NUM_LANES-1:0] capBaStb,
  input  logic [NUM_LANES-1:0] selAb,
  input  logic [NUM_LANES-1:0] selBa,
  input  logic [NUM_LANES-1:0] oeAb,
  input  logic [NUM_LANES-1:0] oeBaN,
  output logic [BUS_W-1:0]     aOut,
  output logic [BUS_W-1:0]     aOe,
  output logic [BUS_W-1:0]     bOut,
  output logic [BUS_W-1:0]     bOe
);
  xcvrStrobes_t strobes;

  dual_bus_xcvr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .capAbStb (capAbStb),
    .capBaStb (capBaStb),
    .selAb    (selAb),
    .selBa    (selBa),
    .oeAb     (oeAb),
    .oeBaN    (oeBaN),
    .strobes  (strobes)
  );

  dual_bus_xcvr_dp #(.LANE_W(LANE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .aIn     (aIn),
    .aDrv    (aDrv),
    .bIn     (bIn),
    .bDrv    (bDrv),
    .aOut    (aOut),
    .aOe     (aOe),
    .bOut    (bOut),
    .bOe     (bOe)
  );
endmodule

// File: rtl/dual_bus_xcvr_chk.sv
module dual_bus_xcvr_chk
  import dual_bus_xcvr_pkg::*;
#(
  parameter  int LANE_W = 9,
  localparam int BUS_W  = NUM_LANES * LANE_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [BUS_W-1:0]     aIn,
  input logic [BUS_W-1:0]     bIn,
  input logic [NUM_LANES-1:0] capAbStb,
  input logic [NUM_LANES-1:0] selAb,
  input logic [NUM_LANES-1:0] selBa,
  input logic [NUM_LANES-1:0] oeAb,
  input logic [NUM_LANES-1:0] oeBaN,
  input logic [BUS_W-1:0]     aOut,
  input logic [BUS_W-1:0]     aOe,
  input logic [BUS_W-1:0]     bOut,
  input logic [BUS_W-1:0]     bOe
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic holdCond;
    assign holdCond = ~selAb[l] & ~selBa[l] & oeAb[l] & ~oeBaN[l];

    // R5
    oe_ab_on_chk: assert property (@(posedge clk) disable iff (!rstN)
      oeAb[l] |=> (&bOe[l*LANE_W +: LANE_W]));
    // R9
    oe_ab_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      !oeAb[l] |=> !(|bOe[l*LANE_W +: LANE_W]));
    // R5
    oe_ba_on_chk: assert property (@(posedge clk) disable iff (!rstN)
      !oeBaN[l] |=> (&aOe[l*LANE_W +: LANE_W]));
    // R4
    live_ab_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!selAb[l] && !holdCond) |=> (bOut[l*LANE_W +: LANE_W] == aIn[l*LANE_W +: LANE_W]));
    // R4
    live_ba_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!selBa[l] && !holdCond) |=> (aOut[l*LANE_W +: LANE_W] == bIn[l*LANE_W +: LANE_W]));
    // R2
    capture_ab_chk: assert property (@(posedge clk) disable iff (!rstN)
      (selAb[l] && capAbStb[l] && !$past(capAbStb[l]))
        |=> (bOut[l*LANE_W +: LANE_W] == $past(aIn[l*LANE_W +: LANE_W])));
    // R6
    stored_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
      (selAb[l] && $past(selAb[l]) && !(capAbStb[l] && !$past(capAbStb[l])))
        |=> $stable(bOut[l*LANE_W +: LANE_W]));
  end
endmodule

bind dual_bus_xcvr dual_bus_xcvr_chk #(.LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .aIn      (aIn),
  .bIn      (bIn),
  .capAbStb (capAbStb),
  .selAb    (selAb),
  .selBa    (selBa),
  .oeAb     (oeAb),
  .oeBaN    (oeBaN),
  .aOut     (aOut),
  .aOe      (aOe),
  .bOut     (bOut),
  .bOe      (bOe)
);

// File: tb/dual_bus_xcvr_bench.sv
`timescale 1ns/1ps
module dual_bus_xcvr_bench;
  import dual_bus_xcvr_pkg::*;
  localparam int W  = 9;
  localparam int L  = NUM_LANES;
  localparam int BW = L * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [BW-1:0] aIn = '0, bIn = '0;
  logic [L-1:0] aDrv = '0, bDrv = '0, capAbStb = '0, capBaStb = '0;
  logic [L-1:0] selAb = '0, selBa = '0, oeAb = '0, oeBaN = '1;
  logic [BW-1:0] aOut, aOe, bOut, bOe;

  dual_bus_xcvr #(.LANE_W(W)) u_dual_bus_xcvr (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aDrv(aDrv), .bIn(bIn), .bDrv(bDrv),
    .capAbStb(capAbStb), .capBaStb(capBaStb), .selAb(selAb), .selBa(selBa),
    .oeAb(oeAb), .oeBaN(oeBaN), .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference model state, derived from the requirements
  logic [W-1:0] mRegAb [L];
  logic [W-1:0] mRegBa [L];
  logic [W-1:0] mHold  [L];
  logic [L-1:0] mPrevAb = '0, mPrevBa = '0;
  logic [L-1:0] mStAb = '0, mStBa = '0, mEnAb = '0, mEnBa = '0, mHoldQ = '0;

  function automatic logic [W-1:0] laneOf(logic [BW-1:0] v, int l);
    return v[l*W +: W];
  endfunction

  function automatic logic [W-1:0] loopVal(logic ad, logic bd, logic [W-1:0] a,
                                           logic [W-1:0] b, logic [W-1:0] h);
    return ad ? a : (bd ? b : h);
  endfunction

  function automatic logic [W-1:0] expOut(logic hold, logic stored, logic [W-1:0] loopv,
                                          logic [W-1:0] regv, logic [W-1:0] live);
    return hold ? loopv : (stored ? regv : live);
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    for (int l = 0; l < L; l++) begin
      if (!rstN) begin
        mRegAb[l] = '0; mRegBa[l] = '0; mHold[l] = '0;
      end else begin
        if (capAbStb[l] && !mPrevAb[l]) mRegAb[l] = laneOf(aIn, l);
        if (capBaStb[l] && !mPrevBa[l]) mRegBa[l] = laneOf(bIn, l);
        if (aDrv[l] || bDrv[l]) mHold[l] = aDrv[l] ? laneOf(aIn, l) : laneOf(bIn, l);
      end
    end
    mPrevAb = capAbStb; mPrevBa = capBaStb;
    mStAb = selAb; mStBa = selBa; mEnAb = oeAb; mEnBa = ~oeBaN;
    mHoldQ = ~selAb & ~selBa & oeAb & ~oeBaN;
  endtask

  task automatic checkAll(string tag);
    for (int l = 0; l < L; l++) begin
      logic [W-1:0] lv, eb, ea;
      string dt;
      lv = loopVal(aDrv[l], bDrv[l], laneOf(aIn, l), laneOf(bIn, l), mHold[l]);
      eb = expOut(mHoldQ[l], mStAb[l], lv, mRegAb[l], laneOf(aIn, l));
      ea = expOut(mHoldQ[l], mStBa[l], lv, mRegBa[l], laneOf(bIn, l));
      dt = (tag != "") ? tag : (mHoldQ[l] ? "R7" : "R4");
      check(mEnAb[l] ? "R5" : "R9", $sformatf("bOe lane%0d", l), laneOf(bOe, l), {W{mEnAb[l]}});
      check(mEnBa[l] ? "R5" : "R9", $sformatf("aOe lane%0d", l), laneOf(aOe, l), {W{mEnBa[l]}});
      if (mEnAb[l]) check(dt, $sformatf("bOut lane%0d", l), laneOf(bOut, l), eb);
      if (mEnBa[l]) check(dt, $sformatf("aOut lane%0d", l), laneOf(aOut, l), ea);
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    modelEdge();
    #1;
    checkAll(tag);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R8: reset clears storage even with strobes high; enables sampled in reset
    rstN = 1'b0; selAb = '1; selBa = '1; oeAb = '1; oeBaN = '0;
    capAbStb = '1; capBaStb = '1; aIn = {4{9'h1a5}}; bIn = {4{9'h0c3}};
    cycle("R8"); cycle("R8");
    // R2: strobe held high across reset release does not capture
    rstN = 1'b1;
    cycle("R2");
    capAbStb = '0; capBaStb = '0;
    cycle("R2");
    // R2: both registers capture on the same edge
    aIn = {9'h101, 9'h0ff, 9'h155, 9'h0aa}; bIn = {9'h033, 9'h1cc, 9'h011, 9'h1ee};
    capAbStb = '1; capBaStb = '1;
    cycle("R2");
    aIn = $urandom(); bIn = $urandom();
    cycle("R2");
    // R3: capture while live and disabled, then read back stored
    capAbStb = '0; capBaStb = '0; selAb = '0; selBa = '0; oeAb = '0; oeBaN = '1;
    cycle("R3");
    aIn = {4{9'h16d}}; bIn = {4{9'h092}}; capAbStb = '1; capBaStb = '1;
    cycle("R3");
    capAbStb = '0; capBaStb = '0; selAb = '1; selBa = '1; oeAb = '1; oeBaN = '0;
    aIn = '0; bIn = '1;
    cycle("R3");
    // R6: select change has no effect before the edge
    selAb = '0; selBa = '0; oeBaN = '1; aIn = {4{9'h0f0}};
    #1 checkAll("R6");
    cycle("R6");
    // R1: only lane 2 stored, others live
    selAb = 4'b0100; oeAb = '1; aIn = {4{9'h13c}};
    cycle("R1");
    aIn = {4{9'h0c6}};
    cycle("R1");
    // R7: self-hold loop follows an external driver and keeps it after release
    selAb = '0; selBa = '0; oeAb = '1; oeBaN = '0;
    aIn = {4{9'h1b7}}; aDrv = '1;
    cycle("R7");
    aDrv = '0; aIn = '0; bIn = '0;
    cycle("R7"); cycle("R7");
    bIn = {4{9'h04e}}; bDrv = '1;
    cycle("R7");
    bDrv = '0; bIn = '1;
    cycle("R7");
    // R8: mid-run reset clears storage and holding value
    selAb = '1; selBa = '1; rstN = 1'b0;
    cycle("R8");
    rstN = 1'b1; selAb = '0; selBa = '0;
    cycle("R8");

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int l = 0; l < L; l++) begin
        if (($urandom() & 3) == 0) begin
          selAb[l] = $urandom(); selBa[l] = $urandom();
          oeAb[l] = $urandom(); oeBaN[l] = $urandom();
        end
      end
      capAbStb = $urandom(); capBaStb = $urandom();
      aIn = {$urandom(), $urandom()}; bIn = {$urandom(), $urandom()};
      for (int l = 0; l < L; l++) begin
        logic hold;
        hold = ~selAb[l] & ~selBa[l] & oeAb[l] & ~oeBaN[l];
        if (hold) begin
          logic [1:0] pick;
          pick = 2'($urandom());
          aDrv[l] = (pick == 2'd1); bDrv[l] = (pick == 2'd2);
        end else begin
          aDrv[l] = oeBaN[l] & 1'($urandom());
          bDrv[l] = ~oeAb[l] & 1'($urandom());
        end
      end
      cycle("");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule